// File: doc/BRIEF.md
# Byte-Doubling Peripheral with Write-Back Master and Level Interrupt

This peripheral sits on a simple register port and exposes four address windows of 64 bytes each. A byte written to the I/O window is doubled and kept for software to read back. A byte written to the memory window is doubled too, but the result goes out to memory. A write-only master carries it as a single 8-byte beat to a 64-bit physical address that software has already programmed in two 32-bit halves.

Both compute paths raise one level interrupt when they finish. Software reads the interrupt flag through a status window and clears it there. Writing a nonzero byte to that window sets the flag by hand. The register port never stalls. Reads are combinational: `rd_data` is valid in the same cycle as the read request and is zero when no read is presented.

Top module: `dbl_periph`

## Requirements
- R1: Address bits [7:6] select the window: 0 is the memory compute window, 1 the I/O window, 2 the status window and 3 the base window. Within a window the low six bits are ignored, except in the base window.
- R2: A single-byte write to the I/O window stores twice the byte. A single-byte read of that window returns the stored value zero-extended to 32 bits.
- R3: A single-byte access has exactly one `req_be` bit set, and the byte is taken from that lane of `req_wdata`. On the I/O, status and memory windows, a write of any other size has no effect and a read of any other size returns 32'hFFFFFFFF.
- R4: A single-byte write to the memory window, made while no transfer is pending, raises `dma_valid` in the next cycle. `dma_addr` then holds the base as it was at the write, and `dma_data` holds twice the byte. All three stay unchanged until `dma_ready` is sampled high.
- R5: A memory-window write that arrives while `dma_valid` is high is dropped, and this includes the cycle in which the beat is accepted.
- R6: The cycle after a beat is accepted (`dma_valid` and `dma_ready` both high), or after an I/O-window byte write, the interrupt flag is set and `irq` is high.
- R7: A single-byte write to the status window with a nonzero byte sets the flag, and a zero byte clears it. A beat accepted in the same cycle wins over a clear. A single-byte read returns the flag in bit 0 with all other bits zero, and `irq` always equals the flag.
- R8: The base window takes only writes with `req_be` = 4'hF. Offset 0 replaces base bits [31:0] and offset 4 replaces bits [63:32]; each write leaves the other half unchanged and other offsets have no effect. Every read of the base window returns 32'hFFFFFFFF.
- R9: The memory window returns 32'hFFFFFFFF on every read.
- R10: Reset clears the stored I/O value, the base, the pending transfer and the flag, so `irq` and `dma_valid` are low.
- R11: Doubling works on the byte zero-extended to 64 bits, so the result is at most 510 (byte 8'hFF gives 64'h1FE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte address; bits [7:6] select the window |
| req_be | input | 4 | Byte enables; also define the access size |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational in the read cycle |
| dma_valid | output | 1 | Memory write beat offered |
| dma_ready | input | 1 | Memory side accepts the beat |
| dma_addr | output | 64 | Physical destination address |
| dma_data | output | 64 | Little-endian 8-byte result |
| irq | output | 1 | Level interrupt |

## Verification
A wrong stored I/O value or flag shows up at `rd_data` on the next read of that window. A wrong flag also shows up on `irq` at the very next clock edge. A corrupted base or a lost doubling appears on `dma_addr`/`dma_data` one cycle after the memory write. A master that lets go of a beat too early or too late shows as `dma_valid` disagreeing with the reference on the cycle after `dma_ready`. Because the model is compared every clock, a divergence is caught within one cycle of the edge that causes it, and does not wait for a later read to expose it.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  typedef enum logic [1:0] {
    WIN_MEM  = 2'd0,
    WIN_IO   = 2'd1,
    WIN_STAT = 2'd2,
    WIN_BASE = 2'd3
  } win_e;

  // Twice the byte, computed on its 64-bit zero extension.
  function automatic logic [63:0] dbl_of(input logic [7:0] b);
    logic [63:0] wide;
    wide = {56'd0, b};
    return wide + wide;
  endfunction

endpackage

// File: rtl/dbl_decode.sv
module dbl_decode
  import dbl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 64,
  parameter int LANES     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LANES-1:0]     req_be,
  input  logic [8*LANES-1:0]   req_wdata,
  output win_e                 win_o,
  output logic                 byte_ok_o,
  output logic [7:0]           byte_o,
  output logic                 rd_o,
  output logic                 wr_mem_o,
  output logic                 wr_io_o,
  output logic                 wr_stat_o,
  output logic                 wr_base_lo_o,
  output logic                 wr_base_hi_o
);
  localparam int WIN_LSB = $clog2(WIN_BYTES);
  localparam int OFF_HI  = LANES;

  logic [WIN_LSB-1:0] offset;
  logic [7:0]         lane_bytes [LANES];
  logic               full_word;
  logic               wr_any;

  assign win_o     = win_e'(req_addr[WIN_LSB +: 2]);
  assign offset    = req_addr[WIN_LSB-1:0];
  assign byte_ok_o = ($countones(req_be) == 1);
  assign full_word = &req_be;
  assign wr_any    = req_valid && req_write;
  assign rd_o      = req_valid && !req_write;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = req_be[g] ? req_wdata[8*g +: 8] : 8'd0;
  end

  always_comb begin
    byte_o = 8'd0;
    for (int i = 0; i < LANES; i++) byte_o = byte_o | lane_bytes[i];
  end

  assign wr_mem_o     = wr_any && byte_ok_o && (win_o == WIN_MEM);
  assign wr_io_o      = wr_any && byte_ok_o && (win_o == WIN_IO);
  assign wr_stat_o    = wr_any && byte_ok_o && (win_o == WIN_STAT);
  assign wr_base_lo_o = wr_any && full_word && (win_o == WIN_BASE) && (offset == '0);
  assign wr_base_hi_o = wr_any && full_word && (win_o == WIN_BASE)
                        && (offset == WIN_LSB'(OFF_HI));

  // R1: a single access drives at most one write strobe
  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_mem_o, wr_io_o, wr_stat_o, wr_base_lo_o, wr_base_hi_o}));

endmodule

// File: rtl/dbl_dma.sv
module dbl_dma #(
  parameter int AW = 64,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  input  logic          dma_ready,
  output logic          dma_valid,
  output logic [AW-1:0] dma_addr,
  output logic [DW-1:0] dma_data,
  output logic          done
);
  logic taken;

  assign done  = dma_valid && dma_ready;
  assign taken = start && !dma_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_valid <= 1'b0;
      dma_addr  <= '0;
      dma_data  <= '0;
    end else if (taken) begin
      dma_valid <= 1'b1;
      dma_addr  <= start_addr;
      dma_data  <= start_data;
    end else if (done) begin
      dma_valid <= 1'b0;
    end
  end

  // R4: an offered beat is held until accepted
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_data));

  // R5: a start during the accept cycle does not relaunch
  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !dma_valid);

endmodule

// File: rtl/dbl_periph.sv
module dbl_periph
  import dbl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 64,
  parameter int LANES     = 4,
  parameter int PA_W      = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LANES-1:0]    req_be,
  input  logic [8*LANES-1:0]  req_wdata,
  output logic [8*LANES-1:0]  rd_data,
  output logic                dma_valid,
  input  logic                dma_ready,
  output logic [PA_W-1:0]     dma_addr,
  output logic [63:0]         dma_data,
  output logic                irq
);
  localparam int DW   = 8 * LANES;
  localparam int HALF = PA_W / 2;

  win_e               win;
  logic               byte_ok, rd_req;
  logic [7:0]         wr_byte;
  logic               wr_mem, wr_io, wr_stat, wr_base_lo, wr_base_hi;
  logic               dma_done;
  logic [63:0]        dbl_w;
  logic [DW-1:0]      io_q;
  logic [PA_W-1:0]    base_q;
  logic               flag_q;

  dbl_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .LANES(LANES)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .win_o(win), .byte_ok_o(byte_ok), .byte_o(wr_byte), .rd_o(rd_req),
    .wr_mem_o(wr_mem), .wr_io_o(wr_io), .wr_stat_o(wr_stat),
    .wr_base_lo_o(wr_base_lo), .wr_base_hi_o(wr_base_hi)
  );

  assign dbl_w = dbl_of(wr_byte);

  dbl_dma #(.AW(PA_W), .DW(64)) u_dma (
    .clk(clk), .rst_n(rst_n),
    .start(wr_mem), .start_addr(base_q), .start_data(dbl_w),
    .dma_ready(dma_ready), .dma_valid(dma_valid),
    .dma_addr(dma_addr), .dma_data(dma_data), .done(dma_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_q   <= '0;
      base_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_io) io_q <= dbl_w[DW-1:0];
      if (wr_base_lo) base_q[HALF-1:0]    <= req_wdata[HALF-1:0];
      if (wr_base_hi) base_q[PA_W-1:HALF] <= req_wdata[HALF-1:0];
      if (dma_done || wr_io)  flag_q <= 1'b1;
      else if (wr_stat)       flag_q <= (wr_byte != 8'd0);
    end
  end

  assign irq = flag_q;

  always_comb begin
    rd_data = '0;
    if (rd_req) begin
      rd_data = '1;
      if (byte_ok && win == WIN_IO)   rd_data = io_q;
      if (byte_ok && win == WIN_STAT) rd_data = DW'(flag_q);
    end
  end

  // R6: completion of either path leaves irq high
  assert_setirq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done || wr_io |=> irq);

  // R7: a software clear without a competing completion drops irq
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && wr_byte == 8'd0 && !dma_done |=> !irq);

  // R3: wrongly sized reads of byte windows give all ones
  assert_badread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !byte_ok && (win == WIN_IO || win == WIN_STAT) |-> rd_data == '1);

  // R8: writing one half of the base keeps the other
  assert_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base_lo |=> $stable(base_q[PA_W-1:HALF]));

  // R11: stored doubled value never exceeds nine significant bits
  assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    io_q[DW-1:9] == '0 && dma_data[63:9] == '0);

endmodule

// File: tb/dbl_periph_bench.sv
module dbl_periph_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        dma_valid, dma_ready = 1'b0;
  logic [63:0] dma_addr, dma_data;
  logic        irq;

  int total = 0, bad = 0;

  // reference state
  bit          m_pend = 0, m_flag = 0;
  logic [63:0] m_addr = 0, m_data = 0, m_base = 0;
  logic [31:0] m_io = 0;

  always #10 clk = ~clk;

  dbl_periph u_dbl_periph (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_data(rd_data), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_addr(dma_addr), .dma_data(dma_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lane_count(input logic [3:0] be);
    int n = 0;
    for (int i = 0; i < 4; i++) if (be[i]) n++;
    return n;
  endfunction

  function automatic logic [7:0] lane_val(input logic [31:0] w, input logic [3:0] be);
    for (int i = 0; i < 4; i++) if (be[i]) return 8'((w >> (8 * i)) & 32'hFF);
    return 8'd0;
  endfunction

  function automatic logic [31:0] exp_read();
    int w = int'(req_addr) / 64;
    bit one = (lane_count(req_be) == 1);
    if (w == 1 && one) return m_io;
    if (w == 2 && one) return {31'd0, m_flag};
    return 32'hFFFF_FFFF;
  endfunction

  // reference model updated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_flag = 0; m_addr = 0; m_data = 0; m_base = 0; m_io = 0;
    end else begin
      int          w;
      bit          one, wr, done;
      logic [7:0]  b;
      logic [63:0] twice;
      w     = int'(req_addr) / 64;
      one   = (lane_count(req_be) == 1);
      wr    = req_valid && req_write;
      b     = lane_val(req_wdata, req_be);
      twice = 64'(b) * 2;
      done  = m_pend && dma_ready;
      if (wr && one && w == 0 && !m_pend) begin
        m_pend = 1; m_addr = m_base; m_data = twice;
      end else if (done) m_pend = 0;
      if (done || (wr && one && w == 1)) m_flag = 1;
      else if (wr && one && w == 2) m_flag = (b != 0);
      if (wr && one && w == 1) m_io = twice[31:0];
      if (wr && req_be == 4'hF && w == 3) begin
        if (int'(req_addr) % 64 == 0) m_base[31:0]  = req_wdata;
        if (int'(req_addr) % 64 == 4) m_base[63:32] = req_wdata;
      end
    end
  end

  // compare on every falling edge, before the inputs move
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 R7 irq", 64'(irq), 64'(m_flag));
      chk("R4 R5 dma_valid", 64'(dma_valid), 64'(m_pend));
      if (m_pend) begin
        chk("R4 R8 dma_addr", dma_addr, m_addr);
        chk("R4 R11 dma_data", dma_data, m_data);
      end
      if (req_valid && !req_write)
        chk("R1 R2 R3 R9 rd_data", 64'(rd_data), 64'(exp_read()));
    end
  end

  task automatic drive(input bit v, input bit w, input logic [7:0] a,
                       input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); #1;
    req_valid = v; req_write = w; req_addr = a; req_be = be; req_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 8'h00, 4'h0, 32'h0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 irq", 64'(irq), 64'h0);
    chk("R10 dma_valid", 64'(dma_valid), 64'h0);
    #1 rst_n = 1'b1;
    // R2 R11: I/O window doubling, byte in lane 2
    drive(1, 1, 8'h47, 4'h4, 32'h00FF_0000);
    drive(1, 0, 8'h40, 4'h2, 32'h0);
    @(negedge clk);
    chk("R2 R11 io readback 1FE", 64'(rd_data), 64'h1FE);
    // R7: clear, then manual set via lane 3
    drive(1, 1, 8'h80, 4'h1, 32'h0);
    drive(1, 1, 8'h9C, 4'h8, 32'h0300_0000);
    drive(1, 0, 8'h80, 4'h8, 32'h0);
    @(negedge clk);
    chk("R7 status read set", 64'(rd_data), 64'h1);
    drive(1, 1, 8'h80, 4'h1, 32'h0);
    // R3: wrong-size write to I/O window ignored
    drive(1, 1, 8'h41, 4'h3, 32'h0000_0505);
    drive(1, 0, 8'h41, 4'h1, 32'h0);
    @(negedge clk);
    chk("R3 io unchanged", 64'(rd_data), 64'h1FE);
    chk("R3 irq untouched", 64'(irq), 64'h0);
    // R8: base halves; odd offset and partial word ignored
    drive(1, 1, 8'hC0, 4'hF, 32'h1234_5678);
    drive(1, 1, 8'hC4, 4'hF, 32'h9ABC_DEF0);
    drive(1, 1, 8'hC8, 4'hF, 32'hFFFF_FFFF);
    drive(1, 1, 8'hC0, 4'h3, 32'hFFFF_FFFF);
    // R4 R5: start DMA with ready low, second write dropped
    dma_ready = 1'b0;
    drive(1, 1, 8'h05, 4'h1, 32'h0000_0021);
    drive(1, 1, 8'h06, 4'h1, 32'h0000_0077);
    @(negedge clk);
    chk("R4 R8 dma_addr", dma_addr, 64'h9ABC_DEF0_1234_5678);
    chk("R4 R5 dma_data", dma_data, 64'h42);
    // R9: memory window read gives all ones
    drive(1, 0, 8'h00, 4'h1, 32'h0);
    drive(0, 0, 8'h00, 4'h0, 32'h0);
    dma_ready = 1'b1;
    idle(3);
    chk("R6 irq after beat", 64'(irq), 64'h1);
    chk("R5 beat not relaunched", 64'(dma_valid), 64'h0);
    // mixed traffic across windows and sizes
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] bes [8] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hF, 4'h0, 4'hC};
      logic [7:0] a;
      a = 8'($urandom);
      if ($urandom % 4 == 0) a = {a[7:6], 6'd0};
      if ($urandom % 4 == 0) a = {a[7:6], 6'd4};
      dma_ready = ($urandom % 3 == 0);
      drive($urandom % 5 != 0, $urandom % 2 == 0, a, bes[$urandom % 8], $urandom);
    end
    idle(2);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule